// File: doc/BRIEF.md
# Hardware Lock Unit for Two Multithreaded Processors

This block is a shared mutual-exclusion service for two processors that each run four hardware threads. A thread whose instruction carries an acquire or release flag sends a request to the unit through its processor's request port. The request is tagged with the thread number and a lock number. One cycle later the unit answers on that processor's response port.

An acquire on a free lock is granted at once. An acquire on a lock held by another thread is answered with "not granted", and the requester is parked in that lock's waiter set. The processor's scheduler then suspends the thread instead of letting it spin. When the owner releases a lock that has waiters, the unit passes ownership directly to one waiter. It then pulses that thread's wake line so its scheduler resumes it. This works whether the waiter sits on the same processor or on the other one.

Threads are numbered globally as g = processor × 4 + thread. The lock table holds, for each lock, a held bit, the global number of the owner and one waiter bit per global thread.

Top module: `lk_sync_unit`

## Requirements
- R1: After reset every lock is free with an empty waiter set, and rsp_valid, rsp_grant, rsp_error and wake are all zero.
- R2: A request presented on processor p in cycle n (req_valid[p]=1) produces rsp_valid[p]=1 in cycle n+1 only. rsp_grant, rsp_error and wake are zero whenever no response carries them.
- R3: An acquire (req_release[p]=0) on a free lock is answered with rsp_grant[p]=1, and the requester becomes the owner.
- R4: An acquire on a lock held by a different thread is answered with rsp_grant[p]=0 and rsp_error[p]=0. The requester is recorded as a waiter, and no wake pulse is produced.
- R5: An acquire by the thread that already owns the lock is answered with rsp_grant[p]=1 and leaves the owner and waiter set unchanged.
- R6: A release (req_release[p]=1) by the owner of a lock with no waiters frees the lock, so a later acquire from any thread is granted.
- R7: A release by the owner of a lock with waiters hands the lock to the first waiter found scanning global thread numbers upward from owner+1, wrapping modulo 8. wake[g] of that waiter is high for exactly one cycle, the same cycle as the release's response.
- R8: The successor chosen in R7 may sit on the other processor from the releasing thread, and its wake bit is raised just the same.
- R9: A release from a thread that does not own the lock, or on a free lock, is answered with rsp_error[p]=1 and rsp_grant[p]=0, and leaves the lock's state unchanged.
- R10: Requests arriving in the same cycle are applied one after another, each seeing the effect of the previous one. Processor 0 goes first after reset, and the first position passes to the next processor after every cycle in which two or more processors present a request.
- R11: Locks are independent: a request on one lock never changes the owner or waiters of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Request present, one bit per processor |
| req_release | input | 2 | 1 = release, 0 = acquire, per processor |
| req_thread | input | 4 | Thread number; processor p uses bits [2p+1:2p] |
| req_lock | input | 8 | Lock number; processor p uses bits [4p+3:4p] |
| rsp_valid | output | 2 | Response present, one cycle after the request |
| rsp_grant | output | 2 | Acquire granted (requester owns the lock) |
| rsp_error | output | 2 | Release rejected because the requester is not the owner |
| wake | output | 8 | One-cycle resume pulse per global thread g = 4p + thread |

## Verification
The bench builds the unit with its default sizes: two processors, four threads each and sixteen locks. With these sizes, all eight waiter bits of a lock can be filled from both processors, and the round-robin scan can wrap past thread 7. Directed sequences cover parking, handover, cross-processor wake, illegal release and the alternating order of simultaneous requests. Randomised traffic is then confined to four locks, so that collisions, simultaneous acquire/release on one lock and long waiter chains occur often, each cycle compared against a behavioural model.

// File: rtl/lk_pkg.sv
package lk_pkg;
    parameter int unsigned LK_NPROC = 2;
    parameter int unsigned LK_NTHR  = 4;
    parameter int unsigned LK_NLOCK = 16;

    localparam int unsigned LK_NT = LK_NPROC * LK_NTHR;
    localparam int unsigned LK_GW = $clog2(LK_NT);
    localparam int unsigned LK_TW = $clog2(LK_NTHR);
    localparam int unsigned LK_LW = $clog2(LK_NLOCK);
    localparam int unsigned LK_PW = (LK_NPROC > 1) ? $clog2(LK_NPROC) : 1;

    typedef enum logic {
        OP_ACQ = 1'b0,
        OP_REL = 1'b1
    } lk_op_e;

    typedef struct packed {
        logic             held;
        logic [LK_GW-1:0] owner;
        logic [LK_NT-1:0] waiters;
    } lk_entry_t;

    typedef struct packed {
        logic             valid;
        lk_op_e           op;
        logic [LK_GW-1:0] gid;
        logic [LK_LW-1:0] lock;
    } lk_req_t;

    typedef struct packed {
        logic valid;
        logic grant;
        logic error;
    } lk_rsp_t;

    typedef struct packed {
        lk_entry_t        entry;
        logic             grant;
        logic             error;
        logic [LK_NT-1:0] wake;
    } lk_step_t;

    // Effect of one request on one lock entry.
    function automatic lk_step_t lk_apply(lk_entry_t e, lk_op_e op, logic [LK_GW-1:0] g);
        lk_step_t r;
        logic     found;
        int       idx;
        r.entry = e;
        r.grant = 1'b0;
        r.error = 1'b0;
        r.wake  = '0;
        found   = 1'b0;
        if (op == OP_ACQ) begin
            if (!e.held) begin
                r.entry.held  = 1'b1;
                r.entry.owner = g;
                r.grant       = 1'b1;
            end else if (e.owner == g) begin
                r.grant = 1'b1;
            end else begin
                r.entry.waiters[g] = 1'b1;
            end
        end else if (!e.held || (e.owner != g)) begin
            r.error = 1'b1;
        end else begin
            for (int k = 1; k <= LK_NT; k++) begin
                idx = (int'(e.owner) + k) % LK_NT;
                if (!found && e.waiters[LK_GW'(idx)]) begin
                    found                          = 1'b1;
                    r.entry.owner                  = LK_GW'(idx);
                    r.entry.waiters[LK_GW'(idx)]   = 1'b0;
                    r.wake[LK_GW'(idx)]            = 1'b1;
                end
            end
            if (!found) begin
                r.entry.held  = 1'b0;
                r.entry.owner = '0;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/lk_order.sv
module lk_order
    import lk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LK_NPROC-1:0] valid,
    output logic [LK_PW-1:0]    first
);
    logic contend;
    assign contend = ($countones(valid) >= 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            first <= '0;
        end else if (contend) begin
            first <= (int'(first) == LK_NPROC - 1) ? '0 : first + 1'b1;
        end
    end

    // R10: the lead position only moves after a contended cycle
    p_first_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !contend |=> $stable(first));
    p_first_range_r10: assert property (@(posedge clk) disable iff (rst)
        int'(first) < LK_NPROC);
endmodule

// File: rtl/lk_table.sv
module lk_table
    import lk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lk_req_t          req   [LK_NPROC],
    input  logic [LK_PW-1:0] first,
    output lk_rsp_t          rsp_n [LK_NPROC],
    output logic [LK_NT-1:0] wake_n
);
    lk_entry_t tbl   [LK_NLOCK];
    lk_entry_t tbl_n [LK_NLOCK];
    lk_step_t  st;

    always_comb begin
        tbl_n  = tbl;
        wake_n = '0;
        st     = '0;
        for (int q = 0; q < LK_NPROC; q++) rsp_n[q] = '0;
        for (int s = 0; s < LK_NPROC; s++) begin : slot
            logic [LK_PW-1:0] pi;
            pi = LK_PW'((int'(first) + s) % LK_NPROC);
            if (req[pi].valid) begin
                st                    = lk_apply(tbl_n[req[pi].lock], req[pi].op, req[pi].gid);
                tbl_n[req[pi].lock]   = st.entry;
                rsp_n[pi].valid       = 1'b1;
                rsp_n[pi].grant       = st.grant;
                rsp_n[pi].error       = st.error;
                wake_n                = wake_n | st.wake;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LK_NLOCK; i++) tbl[i] <= '0;
        end else begin
            tbl <= tbl_n;
        end
    end

    generate
        for (genvar i = 0; i < LK_NLOCK; i++) begin : g_inv
            // R6: a free lock never keeps parked threads
            p_free_no_waiters_r6: assert property (@(posedge clk) disable iff (rst)
                !tbl[i].held |-> (tbl[i].waiters == '0));
            // R4: the owner is never also parked on its own lock
            p_owner_not_parked_r4: assert property (@(posedge clk) disable iff (rst)
                tbl[i].held |-> !tbl[i].waiters[tbl[i].owner]);
        end
    endgenerate
endmodule

// File: rtl/lk_sync_unit.sv
module lk_sync_unit
    import lk_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LK_NPROC-1:0]       req_valid,
    input  logic [LK_NPROC-1:0]       req_release,
    input  logic [LK_NPROC*LK_TW-1:0] req_thread,
    input  logic [LK_NPROC*LK_LW-1:0] req_lock,
    output logic [LK_NPROC-1:0]       rsp_valid,
    output logic [LK_NPROC-1:0]       rsp_grant,
    output logic [LK_NPROC-1:0]       rsp_error,
    output logic [LK_NT-1:0]          wake
);
    lk_req_t          req   [LK_NPROC];
    lk_rsp_t          rsp_n [LK_NPROC];
    logic [LK_NT-1:0] wake_n;
    logic [LK_PW-1:0] first;

    generate
        for (genvar p = 0; p < LK_NPROC; p++) begin : g_port
            assign req[p].valid = req_valid[p];
            assign req[p].op    = req_release[p] ? OP_REL : OP_ACQ;
            assign req[p].gid   = LK_GW'(p * LK_NTHR) + LK_GW'(req_thread[p*LK_TW +: LK_TW]);
            assign req[p].lock  = req_lock[p*LK_LW +: LK_LW];

            always_ff @(posedge clk) begin
                if (rst) begin
                    rsp_valid[p] <= 1'b0;
                    rsp_grant[p] <= 1'b0;
                    rsp_error[p] <= 1'b0;
                end else begin
                    rsp_valid[p] <= rsp_n[p].valid;
                    rsp_grant[p] <= rsp_n[p].grant;
                    rsp_error[p] <= rsp_n[p].error;
                end
            end

            p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
                req_valid[p] |=> rsp_valid[p]);
            p_rsp_silent_r2: assert property (@(posedge clk) disable iff (rst)
                !req_valid[p] |=> !rsp_valid[p] && !rsp_grant[p] && !rsp_error[p]);
            p_grant_is_acquire_r3: assert property (@(posedge clk) disable iff (rst)
                rsp_grant[p] |-> $past(req_valid[p] && !req_release[p]));
            p_error_is_release_r9: assert property (@(posedge clk) disable iff (rst)
                rsp_error[p] |-> !rsp_grant[p] && $past(req_valid[p] && req_release[p]));
        end
    endgenerate

    lk_order u_order (
        .clk   (clk),
        .rst   (rst),
        .valid (req_valid),
        .first (first)
    );

    lk_table u_table (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .first  (first),
        .rsp_n  (rsp_n),
        .wake_n (wake_n)
    );

    always_ff @(posedge clk) begin
        if (rst) wake <= '0;
        else     wake <= wake_n;
    end

    // R7: a resume pulse only follows a release, at most one per releasing processor
    p_wake_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> $past((req_valid & req_release) != '0));
    p_wake_count_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(wake) <= $countones(rsp_valid));
endmodule

// File: tb/tb_lk_sync_unit.sv
`timescale 1ns/1ps
module tb_lk_sync_unit;
    localparam int NP = 2;
    localparam int NT = 8;
    localparam int NL = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req_valid = '0;
    logic [1:0] req_release = '0;
    logic [3:0] req_thread = '0;
    logic [7:0] req_lock = '0;
    logic [1:0] rsp_valid, rsp_grant, rsp_error;
    logic [7:0] wake;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lk_sync_unit dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_release(req_release),
        .req_thread(req_thread), .req_lock(req_lock),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_error(rsp_error), .wake(wake)
    );

    // behavioural reference model
    bit m_held [NL];
    int m_owner [NL];
    bit m_wait [NL][NT];
    int m_first;
    logic [1:0] e_rv, e_gr, e_er;
    logic [7:0] e_wk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NL; i++) begin
                m_held[i] = 0; m_owner[i] = 0;
                for (int j = 0; j < NT; j++) m_wait[i][j] = 0;
            end
            m_first = 0; e_rv = 0; e_gr = 0; e_er = 0; e_wk = 0;
        end else begin
            e_rv = 0; e_gr = 0; e_er = 0; e_wk = 0;
            for (int s = 0; s < NP; s++) begin
                int p, g, l;
                bit hit;
                p = (m_first + s) % NP;
                if (req_valid[p]) begin
                    g = p * 4 + int'(req_thread[p*2 +: 2]);
                    l = int'(req_lock[p*4 +: 4]);
                    e_rv[p] = 1;
                    if (!req_release[p]) begin
                        if (!m_held[l]) begin m_held[l] = 1; m_owner[l] = g; e_gr[p] = 1; end
                        else if (m_owner[l] == g) e_gr[p] = 1;
                        else m_wait[l][g] = 1;
                    end else if (!m_held[l] || m_owner[l] != g) begin
                        e_er[p] = 1;
                    end else begin
                        hit = 0;
                        for (int k = 1; k <= NT; k++) begin
                            int c;
                            c = (g + k) % NT;
                            if (!hit && m_wait[l][c]) begin
                                hit = 1; m_owner[l] = c; m_wait[l][c] = 0; e_wk[c] = 1;
                            end
                        end
                        if (!hit) m_held[l] = 0;
                    end
                end
            end
            if (req_valid == 2'b11) m_first = (m_first + 1) % NP;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            string tag;
            if (e_er != 0) tag = "R9";
            else if (e_wk != 0) tag = "R7";
            else if (e_gr != 0) tag = "R3";
            else tag = "R2";
            check(tag, {8'h0, rsp_valid, rsp_grant, rsp_error, wake, 6'h0},
                       {8'h0, e_rv, e_gr, e_er, e_wk, 6'h0});
        end
    end

    task automatic issue(input logic v0, input logic r0, input logic [1:0] t0, input logic [3:0] l0,
                         input logic v1, input logic r1, input logic [1:0] t1, input logic [3:0] l1);
        req_valid   = {v1, v0};
        req_release = {r1, r0};
        req_thread  = {t1, t0};
        req_lock    = {l1, l0};
        @(negedge clk);
        req_valid = '0;
    endtask

    // rv, grant, error, wake of the response now visible
    task automatic expect_rsp(input string tag, input logic [1:0] rv, input logic [1:0] gr,
                              input logic [1:0] er, input logic [7:0] wk);
        check(tag, {rsp_valid, rsp_grant, rsp_error, wake}, {rv, gr, er, wk});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        expect_rsp("R1", 2'b00, 2'b00, 2'b00, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        // g1 takes lock 3
        issue(1, 0, 2'd1, 4'd3, 0, 0, 2'd0, 4'd0);  expect_rsp("R3", 2'b01, 2'b01, 2'b00, 8'h00);
        // g6 and g3 park on lock 3
        issue(0, 0, 2'd0, 4'd0, 1, 0, 2'd2, 4'd3);  expect_rsp("R4", 2'b10, 2'b00, 2'b00, 8'h00);
        issue(1, 0, 2'd3, 4'd3, 0, 0, 2'd0, 4'd0);  expect_rsp("R4", 2'b01, 2'b00, 2'b00, 8'h00);
        // owner asks again
        issue(1, 0, 2'd1, 4'd3, 0, 0, 2'd0, 4'd0);  expect_rsp("R5", 2'b01, 2'b01, 2'b00, 8'h00);
        // g4 releases a lock it does not hold
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd0, 4'd3);  expect_rsp("R9", 2'b10, 2'b00, 2'b10, 8'h00);
        // g1 releases: scan from g2 finds g3
        issue(1, 1, 2'd1, 4'd3, 0, 0, 2'd0, 4'd0);  expect_rsp("R7", 2'b01, 2'b00, 2'b00, 8'h08);
        @(negedge clk);                              expect_rsp("R7", 2'b00, 2'b00, 2'b00, 8'h00);
        // g3 releases: g6 on the other processor wakes
        issue(1, 1, 2'd3, 4'd3, 0, 0, 2'd0, 4'd0);  expect_rsp("R8", 2'b01, 2'b00, 2'b00, 8'h40);
        // g6 releases with nobody waiting, then g5 gets it
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd2, 4'd3);  expect_rsp("R6", 2'b10, 2'b00, 2'b00, 8'h00);
        issue(0, 0, 2'd0, 4'd0, 1, 0, 2'd1, 4'd3);  expect_rsp("R6", 2'b10, 2'b10, 2'b00, 8'h00);
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd1, 4'd3);  expect_rsp("R6", 2'b10, 2'b00, 2'b00, 8'h00);
        // simultaneous acquires: processor 0 leads first, then processor 1
        issue(1, 0, 2'd0, 4'd5, 1, 0, 2'd0, 4'd5);  expect_rsp("R10", 2'b11, 2'b01, 2'b00, 8'h00);
        issue(1, 0, 2'd0, 4'd7, 1, 0, 2'd0, 4'd7);  expect_rsp("R10", 2'b11, 2'b10, 2'b00, 8'h00);
        // g0 holds lock 5, waits on lock 7, still gets lock 9
        issue(1, 0, 2'd0, 4'd9, 0, 0, 2'd0, 4'd0);  expect_rsp("R11", 2'b01, 2'b01, 2'b00, 8'h00);
        // g7 parks on lock 7; g4 release picks g7 before g0, then wraps to g0
        issue(0, 0, 2'd0, 4'd0, 1, 0, 2'd3, 4'd7);  expect_rsp("R4", 2'b10, 2'b00, 2'b00, 8'h00);
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd0, 4'd7);  expect_rsp("R7", 2'b10, 2'b00, 2'b00, 8'h80);
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd3, 4'd7);  expect_rsp("R7", 2'b10, 2'b00, 2'b00, 8'h01);
        // same cycle: release then acquire of lock 5 in lead order (P0 leads now)
        issue(1, 1, 2'd0, 4'd5, 1, 0, 2'd2, 4'd5);  expect_rsp("R10", 2'b11, 2'b00, 2'b00, 8'h10);
        // lock 9 still owned by g0 despite traffic elsewhere
        issue(0, 0, 2'd0, 4'd0, 1, 1, 2'd0, 4'd9);  expect_rsp("R11", 2'b10, 2'b00, 2'b10, 8'h00);

        // randomised traffic on four locks, checked by the model every cycle
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] v, r, t0, t1;
            logic [3:0] l0, l1;
            for (int p = 0; p < NP; p++) begin
                int l, t;
                v[p] = ($urandom % 10) < 7;
                r[p] = ($urandom % 10) < 4;
                l = $urandom % 4;
                t = $urandom % 4;
                if (r[p] && m_held[l] && (m_owner[l] / 4 == p) && ($urandom % 10) < 8)
                    t = m_owner[l] % 4;
                if (p == 0) begin l0 = 4'(l); t0 = 2'(t); end
                else        begin l1 = 4'(l); t1 = 2'(t); end
            end
            issue(v[0], r[0], t0, l0, v[1], r[1], t1, l1);
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule